// File: doc/BRIEF.md
# Serial Transmitter with Shortened Final Stop Bit

This block turns parallel words into asynchronous serial frames. Software or a bus bridge writes a word into a single holding register. The block moves that word into a frame shifter as soon as the line is free, or at the very end of the frame in flight. Frames that are queued this way go out back to back, with no idle time between them. Bit timing comes from a strobe at sixteen times the bit rate. A select input picks whether the strobe comes from the internal baud divider or from an externally derived clock strobe.

Each frame is a low start bit, then 7, 8 or 9 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The final stop bit can be trimmed to 14 strobes, so the frame is one eighth of a bit shorter. A busy output covers the whole stream of frames. A request output tells the host that the holding register can take another word. An enable input hands the pin to a general-purpose level, which lets software hold the line low for a break.

Top module: `uart_tx_frac`

## Requirements
- R1: A frame starts with one low bit, followed by the data bits least significant first. The count is set by `cfg_len`: 2'b00 sends 7 bits, 2'b01 sends 8 bits, 2'b10 or 2'b11 sends 9 bits. Framing inputs are taken when the word enters the shifter.
- R2: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_odd` = 0 it equals the XOR of the data bits sent, and with 1 it is the inverse of that XOR.
- R3: The frame ends with high stop bits: one when `cfg_two_stop` is 0, two when it is 1.
- R4: Every bit lasts 16 selected strobes. The one exception: when `cfg_short_stop` is 1, the final stop bit of the frame lasts 14 strobes.
- R5: When the line is idle, `tx_busy` rises two clock edges after a write, and the start bit is on `txd` at that moment. It falls on the strobe that ends the final stop bit, and only when no word is waiting.
- R6: `hold_empty` is 1 after reset. A write clears it. It sets again on the edge where the word enters the shifter. A write made while it is 0 is ignored.
- R7: A word that is waiting when a frame ends starts its start bit immediately. `tx_busy` stays high, and the second frame begins on the strobe count that follows directly after the first.
- R8: `cfg_ext_clk` = 0 times bits from `baud_tick`, and 1 times bits from `ext_tick`. The source that is not selected has no effect on timing.
- R9: `tx_irq` is 1 exactly when `cfg_irq_en` is 1 and `hold_empty` is 1.
- R10: When `cfg_line_en` is 1, `txd` is high whenever no frame is being sent. When `cfg_line_en` is 0, `txd` equals `gpo_level`.
- R11: After reset, `txd` is high (with `cfg_line_en` = 1), `tx_busy` is 0 and `hold_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send (upper bits unused for shorter frames) |
| cfg_len | input | 2 | Data length code |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | Odd parity select |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_short_stop | input | 1 | Final stop bit 14/16 long |
| cfg_ext_clk | input | 1 | Timing source select |
| cfg_line_en | input | 1 | Serial function owns the pin |
| cfg_irq_en | input | 1 | Request enable |
| gpo_level | input | 1 | Pin level when the serial function is off |
| baud_tick | input | 1 | 16x strobe from the baud divider |
| ext_tick | input | 1 | 16x strobe from the external clock |
| txd | output | 1 | Serial line |
| tx_busy | output | 1 | Frame stream in progress |
| hold_empty | output | 1 | Holding register can take a word |
| tx_irq | output | 1 | Gated request |

## Verification
The embedded properties watch four things on every cycle: the line never changes inside a frame except on a selected strobe; each frame opens with a low level; busy only drops on a strobe and with the holding register empty; and the empty flag only returns while a frame is running. Bit values, parity polarity, stop-bit count, the 14-strobe trim, the no-gap chaining of queued words and the rejection of writes into a full register are shown only by the bench. It samples the line at mid-bit across random configurations and random strobe patterns on both sources.

// File: rtl/uart_tx_frac.sv
module uart_tx_frac #(
  parameter int TICKS_PER_BIT = 16,
  parameter int SHORT_TICKS   = 14,
  parameter int MAX_DATA      = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [MAX_DATA-1:0] wr_data,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  input  logic                cfg_short_stop,
  input  logic                cfg_ext_clk,
  input  logic                cfg_line_en,
  input  logic                cfg_irq_en,
  input  logic                gpo_level,
  input  logic                baud_tick,
  input  logic                ext_tick,
  output logic                txd,
  output logic                tx_busy,
  output logic                hold_empty,
  output logic                tx_irq
);

  localparam int FW = MAX_DATA + 4;
  localparam int CW = $clog2(TICKS_PER_BIT);
  localparam int NW = $clog2(FW + 1);

  logic [MAX_DATA-1:0] hold_q;
  logic                hold_full;
  logic [FW-1:0]       sh_q;
  logic [NW-1:0]       nbits_q;
  logic [CW-1:0]       sub_q;
  logic                short_q;
  logic                active_q;

  logic                tick;
  logic [FW-1:0]       frame;
  logic [NW-1:0]       nframe;
  int                  ndata;
  logic                par;
  logic                last_bit;
  logic [CW-1:0]       end_cnt;
  logic                bit_done;
  logic                frame_done;
  logic                load;

  assign tick = cfg_ext_clk ? ext_tick : baud_tick;

  always_comb begin
    ndata = (cfg_len == 2'b00) ? MAX_DATA - 2 : (cfg_len == 2'b01) ? MAX_DATA - 1 : MAX_DATA;
    par   = cfg_par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < ndata) begin
        frame[1+i] = hold_q[i];
        par        = par ^ hold_q[i];
      end
    end
    if (cfg_par_en) frame[1+ndata] = par;
    nframe = NW'(ndata + 2 + int'(cfg_par_en) + int'(cfg_two_stop));
  end

  assign last_bit   = (nbits_q == NW'(1));
  assign end_cnt    = (last_bit && short_q) ? CW'(SHORT_TICKS - 1) : CW'(TICKS_PER_BIT - 1);
  assign bit_done   = active_q && tick && (sub_q == end_cnt);
  assign frame_done = bit_done && last_bit;
  assign load       = hold_full && (!active_q || frame_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      sh_q      <= '1;
      nbits_q   <= '0;
      sub_q     <= '0;
      short_q   <= 1'b0;
      active_q  <= 1'b0;
    end else begin
      if (load) begin
        sh_q     <= frame;
        nbits_q  <= nframe;
        sub_q    <= '0;
        short_q  <= cfg_short_stop;
        active_q <= 1'b1;
      end else if (frame_done) begin
        active_q <= 1'b0;
        sh_q     <= '1;
        nbits_q  <= '0;
        sub_q    <= '0;
      end else if (bit_done) begin
        sh_q    <= {1'b1, sh_q[FW-1:1]};
        nbits_q <= nbits_q - NW'(1);
        sub_q   <= '0;
      end else if (active_q && tick) begin
        sub_q <= sub_q + CW'(1);
      end

      if (load)
        hold_full <= 1'b0;
      else if (wr_en)
        hold_full <= 1'b1;

      if (wr_en && !hold_full)
        hold_q <= wr_data;
    end
  end

  assign txd        = cfg_line_en ? (active_q ? sh_q[0] : 1'b1) : gpo_level;
  assign tx_busy    = active_q;
  assign hold_empty = !hold_full;
  assign tx_irq     = cfg_irq_en && hold_empty;

  a_r5_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_busy) && cfg_line_en) |-> !txd);

  a_r5_fall_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> hold_empty);

  a_r8_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(tick));

  a_r6_empty_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> tx_busy);

  a_r4_line_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy) && !$past(tick) && cfg_line_en && $past(cfg_line_en)) |-> $stable(txd));

endmodule

// File: tb/test_uart_tx_frac.sv
module test_uart_tx_frac;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic [1:0] cfg_len = 2'b01;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0, cfg_short_stop = 1'b0;
  logic cfg_ext_clk = 1'b0, cfg_line_en = 1'b1, cfg_irq_en = 1'b0, gpo_level = 1'b1;
  logic baud_tick = 1'b0, ext_tick = 1'b0;
  logic txd, tx_busy, hold_empty, tx_irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  bit    wave  [0:1023];
  bit    expb  [0:31];
  int    expp  [0:31];
  string expr_ [0:31];
  int    nexp;
  int    exp_ticks;

  always #2 clk = ~clk;

  uart_tx_frac i_uart_tx_frac (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_short_stop(cfg_short_stop),
    .cfg_ext_clk(cfg_ext_clk), .cfg_line_en(cfg_line_en), .cfg_irq_en(cfg_irq_en),
    .gpo_level(gpo_level), .baud_tick(baud_tick), .ext_tick(ext_tick),
    .txd(txd), .tx_busy(tx_busy), .hold_empty(hold_empty), .tx_irq(tx_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int data_len(input logic [1:0] c);
    return (c == 2'b00) ? 7 : (c == 2'b01) ? 8 : 9;
  endfunction

  task automatic add_frame(input logic [8:0] d);
    int nd = data_len(cfg_len);
    int j = 0;
    int base = exp_ticks;
    bit p = cfg_par_odd;
    expb[nexp] = 1'b0; expp[nexp] = base + 8; expr_[nexp] = "R1 start"; nexp++; j++;
    for (int i = 0; i < nd; i++) begin
      expb[nexp] = d[i]; expp[nexp] = base + 16*j + 8; expr_[nexp] = "R1 data"; nexp++; j++;
      p ^= d[i];
    end
    if (cfg_par_en) begin
      expb[nexp] = p; expp[nexp] = base + 16*j + 8; expr_[nexp] = "R2 parity"; nexp++; j++;
    end
    for (int s = 0; s < (cfg_two_stop ? 2 : 1); s++) begin
      expb[nexp] = 1'b1; expp[nexp] = base + 16*j + 8; expr_[nexp] = "R3 stop"; nexp++; j++;
    end
    exp_ticks = base + 16*(j-1) + (cfg_short_stop ? 14 : 16);
  endtask

  task automatic run(input int nfr, input logic [8:0] d0, input logic [8:0] d1, input bit junk);
    int k = 0, wi = 0, guard = 0, wcyc = -1, bcyc = -1, n = 0;
    bit started = 0, junk_done = 0, wrote_ok = 0;
    nexp = 0; exp_ticks = 0;
    add_frame(d0);
    if (nfr == 2) add_frame(d1);
    while (guard < 20000) begin
      @(negedge clk); guard++; n++;
      chk(tx_irq == (cfg_irq_en && hold_empty), "R9 irq", tx_irq, cfg_irq_en && hold_empty);
      if (wrote_ok) chk(!hold_empty, "R6 empty clears on write", hold_empty, 0);
      wrote_ok = 0;
      if (tx_busy && !started) begin started = 1; bcyc = n; end
      if (started && !tx_busy && wi == nfr) break;
      wr_en = 1'b0;
      if (wi < nfr && hold_empty) begin
        wr_en = 1'b1; wr_data = (wi == 0) ? d0 : d1; wi++; wrote_ok = 1;
        if (wcyc < 0) wcyc = n;
      end else if (junk && !junk_done && !hold_empty) begin
        wr_en = 1'b1; wr_data = ~d1; junk_done = 1;
      end
      baud_tick = 1'($urandom % 2);
      ext_tick  = 1'($urandom % 2);
      if (tx_busy && (cfg_ext_clk ? ext_tick : baud_tick)) begin
        if (k < 1024) wave[k] = txd;
        k++;
      end
    end
    wr_en = 1'b0; baud_tick = 1'b0; ext_tick = 1'b0;
    chk(bcyc - wcyc == 2, "R5 busy rise delay", bcyc - wcyc, 2);
    chk(k == exp_ticks, nfr == 2 ? "R7 chained length" : (cfg_ext_clk ? "R8 length ext" : "R4 length"), k, exp_ticks);
    chk(txd == 1'b1, "R10 idle high", txd, 1);
    for (int b = 0; b < nexp; b++)
      chk(wave[expp[b]] == expb[b], expr_[b], wave[expp[b]], expb[b]);
  endtask

  initial begin
    while (cyc < 190000) begin
      @(posedge clk); cyc++;
    end
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R11 txd reset", txd, 1);
    chk(tx_busy == 1'b0, "R11 busy reset", tx_busy, 0);
    chk(hold_empty == 1'b1, "R11 empty reset", hold_empty, 1);
    chk(tx_irq == 1'b0, "R9 irq masked", tx_irq, 0);
    cfg_irq_en = 1'b1;
    @(negedge clk);
    chk(tx_irq == 1'b1, "R9 irq enabled", tx_irq, 1);

    cfg_line_en = 1'b0; gpo_level = 1'b0;
    @(negedge clk);
    chk(txd == 1'b0, "R10 break level", txd, 0);
    gpo_level = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R10 gpo high", txd, 1);
    cfg_line_en = 1'b1;

    cfg_len = 2'b00; cfg_par_en = 0; cfg_two_stop = 0; cfg_short_stop = 0; cfg_ext_clk = 0;
    run(1, 9'h055, 9'h000, 0);
    cfg_len = 2'b10; cfg_par_en = 1; cfg_par_odd = 1; cfg_two_stop = 1; cfg_short_stop = 1;
    run(1, 9'h1A3, 9'h000, 1);
    cfg_len = 2'b01; cfg_par_en = 1; cfg_par_odd = 0; cfg_two_stop = 0; cfg_short_stop = 1; cfg_ext_clk = 1;
    run(2, 9'h0F0, 9'h00F, 1);

    for (int t = 0; t < 40; t++) begin
      cfg_len        = 2'($urandom % 4);
      cfg_par_en     = 1'($urandom % 2);
      cfg_par_odd    = 1'($urandom % 2);
      cfg_two_stop   = 1'($urandom % 2);
      cfg_short_stop = 1'($urandom % 2);
      cfg_ext_clk    = 1'($urandom % 2);
      cfg_irq_en     = 1'($urandom % 2);
      run(1 + int'($urandom % 2), 9'($urandom), 9'($urandom), 1'($urandom % 2));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule